// File: doc/BRIEF.md
# Byte-Wide Parallel Flash Command Interpreter

This block is a clocked behavioural model of an 8-bit parallel NOR flash device. The host side drives an address bus, a write-data byte and three active-low strobes (chip select, write strobe, read strobe). All of these are sampled in the system clock domain. Writes are interpreted as multi-cycle command sequences. Each sequence starts with a pair of unlock writes and leads to byte programming, one of three erase sizes, or entry to and exit from an identification mode.

While a program or erase runs, reads return a status byte and not array contents. Software polls this byte until the operation ends. Busy times are counted in clock cycles and set by parameters, so a bench can use short values. The array is a parameterised single-port memory written so that it maps onto block RAM. Erases clear it one byte per cycle.

Top module: `pflash_cmd_model`

## Requirements
- R1: After reset `dout_oe` is low, and every byte of a fresh array reads FFh.
- R2: The writes AAh to 555h, then 55h to 2AAh, then A0h to 555h, followed by one write of (address, data), program that byte. The stored value becomes the old value AND the new data, so bits can only go from 1 to 0. Only the low 11 address bits are compared against 555h and 2AAh.
- R3: The sequence AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, then 30h written to any address inside a sector, sets every byte of that 2^SECT_AW-byte sector to FFh. All other bytes stay unchanged.
- R4: The same prefix followed by 50h written to an address inside a block erases that whole block of 2^BLK_SW sectors and nothing else. When the array holds only one block, this command is ignored.
- R5: The same prefix followed by 10h written to 555h sets the whole array to FFh.
- R6: After AAh/555h, 55h/2AAh, 90h/555h, reads return the identification bytes and not array data. Address bit 0 = 0 gives MFR_ID (9Dh), and bit 0 = 1 gives DEV_ID. All higher address bits are ignored.
- R7: A single write of F0h to any address ends identification mode. So does the three-write sequence that ends in F0h at 555h. Reads then return array data again.
- R8: A write window is open while the chip select and the write strobe are both low and the read strobe is high. The address is taken when the window opens, and the data when it closes. If the read strobe is low, the write is ignored.
- R9: While busy, a read returns a status byte. Bit 7 holds the inverse of bit 7 of the data being programmed, or 0 during an erase. Bits 5..0 read 0.
- R10: While busy, bit 6 of the status byte inverts on each new read. Once the operation ends, reads return true array data and bit 6 no longer changes.
- R11: Every write that ends while a program or erase is busy is ignored. This covers unlock, command and identification writes.
- R12: A write that breaks a sequence (wrong address or wrong data) returns the decoder to idle with no other effect. The next correct sequence then works normally.
- R13: `dout_oe` is high only for a read access, and `dout` is valid three rising edges after the strobes start a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe (output enable), active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data byte |
| dout | output | 8 | Read data, or status while busy |
| dout_oe | output | 1 | High while `dout` carries read data |

## Verification
The strobes are registered on the first rising edge. When a write window closes, it is seen one edge later, and the decoder state or start pulse is updated on the edge after that. An operation therefore starts two edges after the strobes rise, and the bench leaves idle cycles after every write before driving the next one. A read reaches `dout` on the third rising edge after the strobes fall: one edge for input capture, one for array access and the status toggle, and one for the output register. The bench samples on the falling edge that follows, which also keeps status reads inside the busy window. After each program or erase, the bench waits a cycle count worked out from the busy parameters and the number of bytes to clear before it checks array contents.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  localparam int CMD_AW = 11;
  localparam int BYTE_W = 8;

  localparam logic [CMD_AW-1:0] ADR_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_B = 11'h2AA;

  localparam logic [BYTE_W-1:0] K_UNLK1 = 8'hAA;
  localparam logic [BYTE_W-1:0] K_UNLK2 = 8'h55;
  localparam logic [BYTE_W-1:0] K_ESET  = 8'h80;
  localparam logic [BYTE_W-1:0] K_PROG  = 8'hA0;
  localparam logic [BYTE_W-1:0] K_IDIN  = 8'h90;
  localparam logic [BYTE_W-1:0] K_IDOUT = 8'hF0;
  localparam logic [BYTE_W-1:0] K_CHIP  = 8'h10;
  localparam logic [BYTE_W-1:0] K_SECT  = 8'h30;
  localparam logic [BYTE_W-1:0] K_BLK   = 8'h50;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_ESET, SQ_EU1, SQ_EU2, SQ_PROG
  } seq_t;

  typedef enum logic [2:0] {
    EN_IDLE, EN_PRD, EN_PWR, EN_WIPE, EN_HOLD
  } eng_t;

  typedef enum logic [1:0] {
    RG_SECT, RG_BLK, RG_CHIP
  } region_t;
endpackage

// File: rtl/pflash_bus_if.sv
module pflash_bus_if
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic [ADDR_W-1:0] s_addr,
  output logic              w_commit,
  output logic [ADDR_W-1:0] w_addr,
  output logic [BYTE_W-1:0] w_data,
  output logic              rd_act,
  output logic              rd_start
);
  logic              s_ce_n, s_we_n, s_oe_n;
  logic [BYTE_W-1:0] s_din;
  logic              act, act_d, rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ce_n <= 1'b1;
      s_we_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_we_n <= we_n;
      s_oe_n <= oe_n;
      s_addr <= addr;
      s_din  <= din;
    end
  end

  // write window: both strobes low, output strobe high
  assign act      = !s_ce_n && !s_we_n && s_oe_n;
  assign rd_act   = !s_ce_n && !s_oe_n && s_we_n;
  assign w_commit = !act && act_d;
  assign rd_start = rd_act && !rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d  <= 1'b0;
      rd_d   <= 1'b0;
      w_addr <= '0;
      w_data <= '0;
    end else begin
      act_d <= act;
      rd_d  <= rd_act;
      if (act && !act_d) w_addr <= s_addr;
      if (act) w_data <= s_din;
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (act && act_d) |=> $stable(w_addr)); // R8
endmodule

// File: rtl/pflash_cmd_dec.sv
module pflash_cmd_dec
  import pflash_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int SECT_AW = 5,
  parameter int BLK_SW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              w_commit,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [BYTE_W-1:0] w_data,
  input  logic              busy,
  output logic              go_prog,
  output logic              go_erase,
  output region_t           go_rgn,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BYTE_W-1:0] op_data,
  output logic              id_mode
);
  localparam int BLK_AW = SECT_AW + BLK_SW;

  seq_t st;
  logic hit_a, hit_b, blk_ok, wr_ok;

  generate
    if (BLK_AW < ADDR_W) begin : g_blk
      assign blk_ok = 1'b1;
    end else begin : g_noblk
      assign blk_ok = 1'b0;
    end
  endgenerate

  assign hit_a = (w_addr[CMD_AW-1:0] == ADR_A);
  assign hit_b = (w_addr[CMD_AW-1:0] == ADR_B);
  assign wr_ok = w_commit && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      id_mode  <= 1'b0;
      go_prog  <= 1'b0;
      go_erase <= 1'b0;
      go_rgn   <= RG_SECT;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      go_prog  <= 1'b0;
      go_erase <= 1'b0;
      if (wr_ok) begin
        op_addr <= w_addr;
        op_data <= w_data;
        if (st == SQ_PROG) begin
          go_prog <= 1'b1;
          st      <= SQ_IDLE;
        end else if (w_data == K_IDOUT) begin
          id_mode <= 1'b0;
          st      <= SQ_IDLE;
        end else begin
          case (st)
            SQ_IDLE: st <= (hit_a && w_data == K_UNLK1) ? SQ_U1 : SQ_IDLE;
            SQ_U1:   st <= (hit_b && w_data == K_UNLK2) ? SQ_U2 : SQ_IDLE;
            SQ_U2: begin
              st <= SQ_IDLE;
              if (hit_a) begin
                if (w_data == K_ESET)      st <= SQ_ESET;
                else if (w_data == K_PROG) st <= SQ_PROG;
                else if (w_data == K_IDIN) id_mode <= 1'b1;
              end
            end
            SQ_ESET: st <= (hit_a && w_data == K_UNLK1) ? SQ_EU1 : SQ_IDLE;
            SQ_EU1:  st <= (hit_b && w_data == K_UNLK2) ? SQ_EU2 : SQ_IDLE;
            SQ_EU2: begin
              st <= SQ_IDLE;
              if (hit_a && w_data == K_CHIP) begin
                go_erase <= 1'b1;
                go_rgn   <= RG_CHIP;
              end else if (w_data == K_SECT) begin
                go_erase <= 1'b1;
                go_rgn   <= RG_SECT;
              end else if (w_data == K_BLK && blk_ok) begin
                go_erase <= 1'b1;
                go_rgn   <= RG_BLK;
              end
            end
            default: st <= SQ_IDLE;
          endcase
        end
      end
    end
  end

  AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_prog, go_erase})); // R3

  AST_ID_LEAVE: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && w_data == K_IDOUT && st != SQ_PROG) |=> !id_mode); // R7
endmodule

// File: rtl/pflash_engine.sv
module pflash_engine
  import pflash_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SECT_AW      = 5,
  parameter int BLK_SW       = 4,
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_prog,
  input  logic              go_erase,
  input  region_t           go_rgn,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [BYTE_W-1:0] op_data,
  input  logic [BYTE_W-1:0] m_q,
  output logic              busy,
  output logic              is_prog,
  output logic              prog_b7,
  output logic              m_own,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_we,
  output logic [BYTE_W-1:0] m_wd
);
  localparam int BLK_AW  = SECT_AW + BLK_SW;
  localparam int LIM_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int TMR_W   = $clog2(LIM_MAX + 1) + 1;
  localparam logic [ADDR_W-1:0] SECT_MSK = ADDR_W'((64'd1 << SECT_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] BLK_MSK  = ADDR_W'((64'd1 << BLK_AW) - 64'd1);

  eng_t              st;
  logic [ADDR_W-1:0] ptr, last;
  logic [BYTE_W-1:0] pdata;
  logic [TMR_W-1:0]  timer, lim;
  logic [ADDR_W-1:0] msk;

  always_comb begin
    case (go_rgn)
      RG_SECT: msk = SECT_MSK;
      RG_BLK:  msk = BLK_MSK;
      default: msk = '1;
    endcase
  end

  assign lim     = is_prog ? TMR_W'(PROG_CYCLES - 1) : TMR_W'(ERASE_CYCLES - 1);
  assign busy    = (st != EN_IDLE);
  assign m_own   = (st == EN_PRD) || (st == EN_PWR) || (st == EN_WIPE);
  assign m_we    = (st == EN_PWR) || (st == EN_WIPE);
  assign m_wd    = (st == EN_PWR) ? (m_q & pdata) : '1;
  assign m_addr  = ptr;
  assign prog_b7 = pdata[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= EN_IDLE;
      ptr     <= '0;
      last    <= '0;
      pdata   <= '0;
      timer   <= '0;
      is_prog <= 1'b0;
    end else begin
      if (st != EN_IDLE && timer != {TMR_W{1'b1}}) timer <= timer + 1'b1;
      case (st)
        EN_IDLE: begin
          timer <= '0;
          if (go_prog) begin
            st      <= EN_PRD;
            ptr     <= op_addr;
            pdata   <= op_data;
            is_prog <= 1'b1;
          end else if (go_erase) begin
            st      <= EN_WIPE;
            ptr     <= op_addr & ~msk;
            last    <= op_addr | msk;
            is_prog <= 1'b0;
          end
        end
        EN_PRD: st <= EN_PWR;
        EN_PWR: st <= EN_HOLD;
        EN_WIPE: begin
          ptr <= ptr + 1'b1;
          if (ptr == last) st <= EN_HOLD;
        end
        EN_HOLD: if (timer >= lim) st <= EN_IDLE;
        default: st <= EN_IDLE;
      endcase
    end
  end

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(go_prog || go_erase)); // R11
endmodule

// File: rtl/pflash_array.sv
module pflash_array
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a,
  input  logic              we,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
    q <= mem[a];
  end
endmodule

// File: rtl/pflash_cmd_model.sv
module pflash_cmd_model
  import pflash_pkg::*;
#(
  parameter int          ADDR_W       = 11,
  parameter int          SECT_AW      = 5,
  parameter int          BLK_SW       = 4,
  parameter int          PROG_CYCLES  = 40,
  parameter int          ERASE_CYCLES = 100,
  parameter logic [7:0]  MFR_ID       = 8'h9D,
  parameter logic [7:0]  DEV_ID       = 8'h3E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe
);
  logic [ADDR_W-1:0] s_addr, w_addr, op_addr, eng_addr, mem_a;
  logic [BYTE_W-1:0] w_data, op_data, m_q, m_wd, rd_word;
  logic              w_commit, rd_act, rd_start;
  logic              go_prog, go_erase, id_mode;
  region_t           go_rgn;
  logic              busy, is_prog, prog_b7, m_own, m_we;
  logic              tog, rd_q, busy_q, id_q, sel_q;

  pflash_bus_if #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .s_addr(s_addr), .w_commit(w_commit),
    .w_addr(w_addr), .w_data(w_data), .rd_act(rd_act), .rd_start(rd_start)
  );

  pflash_cmd_dec #(.ADDR_W(ADDR_W), .SECT_AW(SECT_AW), .BLK_SW(BLK_SW)) u_dec (
    .clk(clk), .rst(rst), .w_commit(w_commit), .w_addr(w_addr),
    .w_data(w_data), .busy(busy), .go_prog(go_prog), .go_erase(go_erase),
    .go_rgn(go_rgn), .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode)
  );

  pflash_engine #(
    .ADDR_W(ADDR_W), .SECT_AW(SECT_AW), .BLK_SW(BLK_SW),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_eng (
    .clk(clk), .rst(rst), .go_prog(go_prog), .go_erase(go_erase),
    .go_rgn(go_rgn), .op_addr(op_addr), .op_data(op_data), .m_q(m_q),
    .busy(busy), .is_prog(is_prog), .prog_b7(prog_b7), .m_own(m_own),
    .m_addr(eng_addr), .m_we(m_we), .m_wd(m_wd)
  );

  assign mem_a = m_own ? eng_addr : s_addr;

  pflash_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .a(mem_a), .we(m_we), .wd(m_wd), .q(m_q)
  );

  always_comb begin
    if (busy_q)    rd_word = {(is_prog ? ~prog_b7 : 1'b0), tog, 6'b000000};
    else if (id_q) rd_word = sel_q ? DEV_ID : MFR_ID;
    else           rd_word = m_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog     <= 1'b0;
      rd_q    <= 1'b0;
      busy_q  <= 1'b0;
      id_q    <= 1'b0;
      sel_q   <= 1'b0;
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      rd_q   <= rd_act;
      busy_q <= busy;
      id_q   <= id_mode;
      sel_q  <= s_addr[0];
      if (rd_start && busy) tog <= ~tog;
      dout_oe <= rd_q;
      dout    <= rd_q ? rd_word : '0;
    end
  end

  AST_OE_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(rd_act, 2)); // R13
endmodule

// File: tb/pflash_cmd_model_test.sv
module pflash_cmd_model_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_oe;
  int          checks = 0;
  int          errors = 0;
  logic        last_oe;

  always #4 clk = ~clk;

  pflash_cmd_model #(
    .ADDR_W(11), .SECT_AW(5), .BLK_SW(4),
    .PROG_CYCLES(40), .ERASE_CYCLES(100),
    .MFR_ID(8'h9D), .DEV_ID(8'h3E)
  ) uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // strobe opens late on chip select, closes early on chip select
  task automatic wr_split(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = 11'h000; din = 8'h00; we_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); addr = a; din = d; ce_n = 1'b0;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1; din = ~d; addr = 11'h000;
    @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_oe_low(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); d = dout; last_oe = dout_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  task automatic cmd(input logic [7:0] c);
    unlock();
    wr(11'h555, c);
  endtask

  task automatic prog(input logic [10:0] a, input logic [7:0] d);
    cmd(8'hA0);
    wr(a, d);
  endtask

  task automatic erase(input logic [7:0] code, input logic [10:0] a);
    cmd(8'h80);
    unlock();
    wr(a, code);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 oe after reset", {7'd0, dout_oe}, 8'h00);
    rd(11'h000, d); chk("R1 fresh byte 000", d, 8'hFF);
    chk("R13 oe during read", {7'd0, last_oe}, 8'h01);
    rd(11'h7FF, d); chk("R1 fresh byte 7FF", d, 8'hFF);
    idle(2);
    chk("R13 oe idle", {7'd0, dout_oe}, 8'h00);
  endtask

  task automatic t_program();
    logic [7:0] d;
    prog(11'h123, 8'h5A); idle(80);
    rd(11'h123, d); chk("R2 program", d, 8'h5A);
    prog(11'h123, 8'h0F); idle(80);
    rd(11'h123, d); chk("R2 and-only", d, 8'h0A);
    prog(11'h123, 8'hFF); idle(80);
    rd(11'h123, d); chk("R2 no bit set back", d, 8'h0A);
  endtask

  task automatic t_status();
    logic [7:0] d1, d2, d3;
    prog(11'h130, 8'h3C);
    rd(11'h130, d1);
    chk("R9 prog bit7 inverted", {7'd0, d1[7]}, 8'h01);
    chk("R9 low bits zero", d1 & 8'h3F, 8'h00);
    rd(11'h130, d2);
    chk("R10 toggle", {7'd0, d2[6]}, {7'd0, ~d1[6]});
    idle(80);
    rd(11'h130, d1); chk("R10 true data after", d1, 8'h3C);
    rd(11'h130, d2); chk("R10 no toggle after", d2, 8'h3C);
    prog(11'h131, 8'hC3);
    rd(11'h131, d3);
    chk("R9 prog bit7 inverted one", {7'd0, d3[7]}, 8'h00);
    idle(80);
  endtask

  task automatic t_sector();
    logic [7:0] d;
    prog(11'h045, 8'h00); idle(80);
    prog(11'h065, 8'h00); idle(80);
    prog(11'h03F, 8'h00); idle(80);
    erase(8'h30, 11'h04A);
    rd(11'h045, d); chk("R9 erase bit7 zero", {7'd0, d[7]}, 8'h00);
    idle(200);
    rd(11'h045, d); chk("R3 sector erased", d, 8'hFF);
    rd(11'h065, d); chk("R3 next sector kept", d, 8'h00);
    rd(11'h03F, d); chk("R3 prev sector kept", d, 8'h00);
  endtask

  task automatic t_block();
    logic [7:0] d;
    prog(11'h200, 8'h11); idle(80);
    prog(11'h3FF, 8'h22); idle(80);
    prog(11'h1FF, 8'h33); idle(80);
    prog(11'h400, 8'h44); idle(80);
    erase(8'h50, 11'h2AB);
    idle(700);
    rd(11'h200, d); chk("R4 block low end", d, 8'hFF);
    rd(11'h3FF, d); chk("R4 block high end", d, 8'hFF);
    rd(11'h1FF, d); chk("R4 lower block kept", d, 8'h33);
    rd(11'h400, d); chk("R4 upper block kept", d, 8'h44);
  endtask

  task automatic t_chip();
    logic [7:0] d;
    prog(11'h010, 8'h00); idle(80);
    erase(8'h10, 11'h555);
    prog(11'h011, 8'h00);
    cmd(8'h90);
    idle(2300);
    rd(11'h010, d); chk("R5 chip erased", d, 8'hFF);
    rd(11'h400, d); chk("R5 chip erased far", d, 8'hFF);
    rd(11'h011, d); chk("R11 program while busy ignored", d, 8'hFF);
    rd(11'h000, d); chk("R11 id entry while busy ignored", d, 8'hFF);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    cmd(8'h90);
    rd(11'h000, d); chk("R6 maker id", d, 8'h9D);
    rd(11'h001, d); chk("R6 device id", d, 8'h3E);
    rd(11'h401, d); chk("R6 upper bits ignored", d, 8'h3E);
    rd(11'h7FE, d); chk("R6 upper bits ignored maker", d, 8'h9D);
    wr(11'h7FF, 8'hF0);
    rd(11'h000, d); chk("R7 single exit", d, 8'hFF);
    cmd(8'h90);
    rd(11'h001, d); chk("R6 reentry", d, 8'h3E);
    cmd(8'hF0);
    rd(11'h001, d); chk("R7 three-cycle exit", d, 8'hFF);
  endtask

  task automatic t_badseq();
    logic [7:0] d;
    wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'hA0); wr(11'h050, 8'h00);
    idle(80);
    rd(11'h050, d); chk("R12 wrong address", d, 8'hFF);
    unlock(); wr(11'h555, 8'h77); wr(11'h051, 8'h00);
    idle(80);
    rd(11'h051, d); chk("R12 wrong code", d, 8'hFF);
    prog(11'h050, 8'h12); idle(80);
    rd(11'h050, d); chk("R12 recovery", d, 8'h12);
  endtask

  task automatic t_bus();
    logic [7:0] d;
    wr_split(11'h555, 8'hAA); wr_split(11'h2AA, 8'h55);
    wr_split(11'h555, 8'hA0); wr_split(11'h088, 8'h5A);
    idle(80);
    rd(11'h088, d); chk("R8 late address early data", d, 8'h5A);
    cmd(8'hA0);
    wr_oe_low(11'h089, 8'h00);
    idle(80);
    rd(11'h089, d); chk("R8 write with oe low ignored", d, 8'hFF);
    wr(11'h08A, 8'h3C); idle(80);
    rd(11'h08A, d); chk("R8 sequence kept waiting", d, 8'h3C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_program();
    t_status();
    t_sector();
    t_block();
    t_chip();
    t_ident();
    t_badseq();
    t_bus();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule